// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

The block is a synchronous binary counter with one clock. On each rising edge it does one of four things: it takes a parallel data word, steps up by one, steps down by one, or keeps its value. A load request always wins over counting. With count enable low, the load path alone turns the block into a plain data register of the same width. The count output is the state register itself.

A terminal-count output lets several stages be chained into a wider counter. Terminal count is combinational. It is high only while count enable is high and the state sits at the last value in the current direction: all ones when counting up, all zeros when counting down. To chain stages, wire each stage's terminal count to the count enable of the next stage. All stages share the clock, the direction and the load signals. The width is a parameter with a default of 4, which gives 16 states.

Top module: `updown_cascade_ctr`

## Requirements
- R1: While `rst_n` is low, the count output is 0, and it goes to 0 at once, without waiting for a clock edge. With `cnt_en` low, `tc` is 0 during reset.
- R2: With `load` high, the next rising edge writes `din` into the count, whatever `cnt_en` and `dir_up` are. Load takes priority over counting.
- R3: With `load` low, `cnt_en` high and `dir_up` high (1 = up), each rising edge adds one. All ones wraps to 0.
- R4: With `load` low, `cnt_en` high and `dir_up` low (0 = down), each rising edge subtracts one. 0 wraps to all ones.
- R5: With `load` and `cnt_en` both low, the count keeps its value across edges, and `dir_up` has no effect on it.
- R6: `tc` is high exactly when `cnt_en` is high and either `dir_up` is 1 with the count at all ones, or `dir_up` is 0 with the count at 0. It follows its inputs within the same cycle.
- R7: Two stages with the low stage's `tc` driving the high stage's `cnt_en`, sharing `dir_up` and `load`, count as one counter of twice the width in both directions.
- R8: The width is set by the parameter `WIDTH` (default 4). Terminal-count detection uses all ones and all zeros at any width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| cnt_en | input | 1 | Count enable; also gates terminal count |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| load | input | 1 | Parallel load request |
| din | input | WIDTH | Parallel data word |
| q | output | WIDTH | Current count (state register) |
| tc | output | 1 | Terminal count for cascading |

## Verification
On every cycle, the in-line assertions check the one-edge effect of each mode: load, step up with wrap, step down with wrap, and hold. They also check that terminal count never rises without enable and that it matches the direction-dependent end value. Only the bench scenarios can show the rest. These are the asynchronous clear in the middle of a cycle, that load wins while enable is high, and that a chained pair of stages carries and borrows correctly across the boundary between nibbles in both directions.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_LOAD = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_dec.sv
module ctr_op_dec
  import ctr_pkg::*;
(
  input  logic    load,
  input  logic    cnt_en,
  input  logic    dir_up,
  output ctr_op_e op
);
  always_comb begin
    if (load)        op = OP_LOAD;
    else if (!cnt_en) op = OP_HOLD;
    else if (dir_up) op = OP_UP;
    else             op = OP_DOWN;
  end
endmodule

// File: rtl/ctr_next.sv
module ctr_next
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = din;
      OP_UP:   nxt = cur + ONE;
      OP_DOWN: nxt = cur - ONE;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_tc.sv
module ctr_tc #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             cnt_en,
  input  logic             dir_up,
  output logic             tc
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ALL_ZERO = '0;

  logic at_top, at_bot;
  assign at_top = (cur == ALL_ONES);
  assign at_bot = (cur == ALL_ZERO);
  assign tc = cnt_en & (dir_up ? at_top : at_bot);
endmodule

// File: rtl/updown_cascade_ctr.sv
module updown_cascade_ctr
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             dir_up,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             tc
);
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  ctr_op_e          op;
  logic [WIDTH-1:0] state_q, state_d;

  ctr_op_dec u_dec (
    .load   (load),
    .cnt_en (cnt_en),
    .dir_up (dir_up),
    .op     (op)
  );

  ctr_next #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .cur (state_q),
    .din (din),
    .nxt (state_d)
  );

  ctr_tc #(.WIDTH(WIDTH)) u_tc (
    .cur    (state_q),
    .cnt_en (cnt_en),
    .dir_up (dir_up),
    .tc     (tc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign q = state_q;

  a_r2_load_takes_din: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(din)));

  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_en && dir_up) |=> (q == $past(q) + ONE));

  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_en && !dir_up) |=> (q == $past(q) - ONE));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cnt_en) |=> $stable(q));

  a_r6_tc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> cnt_en);

  a_r6_tc_end_value: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (dir_up ? (q == ALL_ONES) : (q == '0)));
endmodule

// File: tb/updown_cascade_ctr_tb.sv
module updown_cascade_ctr_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n, cnt_en, dir_up, load;
  logic [W-1:0] din;
  logic [W-1:0] q_lo, q_hi;
  logic tc_lo, tc_hi;

  int compared = 0;
  int mismatched = 0;

  logic [2*W-1:0] exp_q[$];
  string          exp_tag[$];
  logic [2*W-1:0] model;

  always #2.5 clk = ~clk;

  updown_cascade_ctr #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_up(dir_up),
    .load(load), .din(din), .q(q_lo), .tc(tc_lo)
  );

  // R7: high stage enabled by low stage terminal count
  updown_cascade_ctr #(.WIDTH(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .cnt_en(tc_lo), .dir_up(dir_up),
    .load(load), .din(din), .q(q_hi), .tc(tc_hi)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver: apply inputs, check tc now, push expected count after the edge
  task automatic step(input logic ld, input logic en, input logic up,
                      input logic [W-1:0] d, input string tag);
    logic exp_tc;
    @(negedge clk);
    load = ld; cnt_en = en; dir_up = up; din = d;
    #0.5;
    exp_tc = en & (up ? (model[W-1:0] == {W{1'b1}}) : (model[W-1:0] == '0));
    check({"R6 tc ", tag}, {31'd0, tc_lo}, {31'd0, exp_tc});
    if (ld)       model = {d, d};
    else if (en)  model = up ? model + 1'b1 : model - 1'b1;
    exp_q.push_back(model);
    exp_tag.push_back(tag);
  endtask

  // monitor: compare after each edge with a pending item
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [2*W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = exp_tag.pop_front();
      #1;
      check(t, {24'd0, q_hi, q_lo}, {24'd0, e});
    end
  end

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_en = 1'b0; dir_up = 1'b1; load = 1'b0; din = '0;
    model = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset count", {24'd0, q_hi, q_lo}, 32'd0);
    check("R1 reset tc", {31'd0, tc_lo}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step(1, 0, 1, 4'hE, "R2 load without enable");
    step(1, 0, 0, 4'hE, "R2 reload same");
    step(0, 1, 1, 4'h0, "R3 up to EF");
    step(0, 1, 1, 4'h0, "R7 carry into high stage");
    step(0, 1, 1, 4'h0, "R3 up to F1");
    step(1, 1, 1, 4'h5, "R2 load beats count");
    step(0, 0, 0, 4'hA, "R5 hold dir down");
    step(0, 0, 1, 4'h3, "R5 hold dir up");
    step(1, 0, 1, 4'h0, "R2 load zero");
    step(0, 1, 0, 4'h0, "R4 wrap 00 to FF");
    step(0, 1, 0, 4'h0, "R4 down to FE");
    step(1, 0, 0, 4'h0, "R2 load 00");
    step(0, 1, 0, 4'h0, "R4 R7 borrow 00 to FF");
    step(1, 0, 1, 4'h1, "R2 load 11");
    step(0, 1, 0, 4'h0, "R7 down 11 to 10");
    step(0, 1, 0, 4'h0, "R7 borrow 10 to 0F");
    step(1, 0, 1, 4'hF, "R2 load FF");
    step(0, 1, 1, 4'h0, "R3 R8 wrap FF to 00");
    for (int i = 0; i < 20; i++) step(0, 1, 1, 4'h0, "R3 run up");
    for (int i = 0; i < 25; i++) step(0, 1, 0, 4'h0, "R4 run down");
    step(0, 0, 1, 4'h0, "R5 final hold");
    @(posedge clk); #2;

    // R1: asynchronous clear in mid-cycle
    @(negedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    check("R1 async clear", {24'd0, q_hi, q_lo}, 32'd0);
    model = '0;
    @(negedge clk); rst_n = 1'b1;
    step(0, 1, 0, 4'h0, "R6 R4 after reset");
    @(posedge clk); #2;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule